// File: doc/BRIEF.md
# Command-Addressed Serial Register Port

This block is a serial-bus slave that lets an external host read and write a small bank of internal registers. The host selects the block with an active-low chip select and clocks bits with a serial clock that idles high. Every access opens with one command byte. That byte picks the direction and a 6-bit register address. It is followed by one, two or three data bytes. The number of data bytes follows from the width of the addressed register. Data travels most significant byte first and is right-justified within its bytes.

The serial inputs are brought into the system clock domain through two-stage synchronizers, and their edges are detected there. The serial clock must therefore run well below the system clock. Each incoming data byte is committed to its register as soon as its last bit arrives, and the next byte can already be shifting in. Read data is latched into an output shift register when the command byte completes. The output enable is separate from the data bit, so the pad can be tri-stated outside a read. Raising chip select abandons any transfer and discards an incomplete byte. After the last bit of a transfer the block waits for a new command byte, even if chip select stays low.

Top module: `spi_regbank_slave`

## Requirements
- R1: `sdi` is sampled on falling edges of `sclk`, and `sdo` changes only after rising edges of `sclk`. `sdo` stays unchanged while `sclk` is low.
- R2: In the command byte, bit 7 = 1 selects a write and bit 7 = 0 selects a read. Bits 5..0 give the register address, and bit 6 has no effect.
- R3: While `cs_n` is high, `sdo_oe` is low. Raising `cs_n` in the middle of a data byte leaves that byte unwritten. Bytes of the same write that completed earlier are kept.
- R4: After `cs_n` has been high, the first byte shifted once it falls is taken as a command byte, whatever happened before.
- R5: Register width for an address a below 16 follows a mod 4: 0 gives 8 bits, 1 gives 12 bits, 2 gives 16 bits, 3 gives 24 bits. A transfer moves ceil(width/8) data bytes.
- R6: Data bytes travel most significant byte first. The first data byte of a write goes to the highest byte of the register, and a read returns the highest byte first.
- R7: Data is right-justified. Bits of the first byte above the register width are dropped on write and read back as zero.
- R8: After the last bit of a transfer the block expects a new command byte without any toggle of `cs_n`, so back-to-back transactions in one selection work.
- R9: Addresses 16 to 63 are one byte wide. Writes to them have no effect, and reads from them return zero.
- R10: While `rst_n` is low at a clock edge, all registers clear, `sdo_oe` and `sdo` go low, and the block waits for a command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock from the host, idle high |
| cs_n | input | 1 | Active-low chip select |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host |
| sdo_oe | output | 1 | Output enable for the `sdo` pad (1 = drive) |

## Verification
A change on `sclk` reaches the edge detector two system clocks later. `sdo` takes its new bit on the third clock after the rising edge of `sclk`. A completed write byte lands in its register on the fourth clock after the falling edge that ends it. The bench holds every serial level for six system clocks before it moves `sclk`, and it samples `sdo` only in the last cycle before each falling edge, so every registered result is in place when it is sampled. Register contents are judged only through complete read transactions. A reference model applies the width, packing and abort rules, and every read is compared against it.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;

    localparam int ADDR_W = 6;
    localparam int REG_W  = 24;

    typedef enum logic [1:0] {
        PH_CMD = 2'd0,
        PH_WR  = 2'd1,
        PH_RD  = 2'd2
    } phase_e;

    // Bit width of the register at an address; unimplemented slots count as 8.
    function automatic logic [4:0] rb_bits(input logic [ADDR_W-1:0] a, input int unsigned n);
        if (32'(a) >= n) return 5'd8;
        case (a[1:0])
            2'd0:    return 5'd8;
            2'd1:    return 5'd12;
            2'd2:    return 5'd16;
            default: return 5'd24;
        endcase
    endfunction

    function automatic logic [1:0] rb_bytes(input logic [ADDR_W-1:0] a, input int unsigned n);
        logic [5:0] t;
        t = {1'b0, rb_bits(a, n)} + 6'd7;
        return t[4:3];
    endfunction

    // Storage mask: zero for unimplemented slots, low `bits` ones otherwise.
    function automatic logic [REG_W-1:0] rb_mask(input logic [ADDR_W-1:0] a, input int unsigned n);
        logic [REG_W:0] m;
        if (32'(a) >= n) return '0;
        m = ((REG_W+1)'(1) << rb_bits(a, n)) - (REG_W+1)'(1);
        return m[REG_W-1:0];
    endfunction

endpackage

// File: rtl/spi_rb_sync.sv
module spi_rb_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage_q [STAGES];
    logic [W-1:0] stage_d [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) stage_d[i] = stage_q[i-1];
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < STAGES; i++) begin
            if (!rst_n) stage_q[i] <= RST_VAL;
            else        stage_q[i] <= stage_d[i];
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_rb_regfile.sv
module spi_rb_regfile
    import spi_rb_pkg::*;
#(
    parameter int NUM_REGS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [1:0]        wsel,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [REG_W-1:0]  rdata
);
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic [REG_W-1:0] mem_q [NUM_REGS];
    logic [REG_W-1:0] mem_d [NUM_REGS];
    logic [REG_W-1:0] merged;
    logic             w_hit;

    assign w_hit = we && (32'(waddr) < NUM_REGS);

    always_comb begin
        for (int i = 0; i < NUM_REGS; i++) mem_d[i] = mem_q[i];
        merged = mem_q[waddr[IDX_W-1:0]];
        merged[8*wsel +: 8] = wdata;
        if (w_hit) mem_d[waddr[IDX_W-1:0]] = merged & rb_mask(waddr, NUM_REGS);
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_REGS; i++) begin
            if (!rst_n) mem_q[i] <= '0;
            else        mem_q[i] <= mem_d[i];
        end
    end

    assign rdata = (32'(raddr) < NUM_REGS) ? mem_q[raddr[IDX_W-1:0]] : '0;

    // R7: stored contents never reach above the register width
    assert_width_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(raddr) < NUM_REGS) |-> ((rdata & ~rb_mask(raddr, NUM_REGS)) == '0));
endmodule

// File: rtl/spi_rb_ctrl.sv
module spi_rb_ctrl
    import spi_rb_pkg::*;
#(
    parameter int NUM_REGS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              cs_s,
    input  logic              sdi_s,
    input  logic [REG_W-1:0]  rdata,
    output logic [ADDR_W-1:0] raddr,
    output logic              we,
    output logic [ADDR_W-1:0] waddr,
    output logic [1:0]        wsel,
    output logic [7:0]        wdata,
    output logic              sdo,
    output logic              sdo_oe
);
    typedef struct packed {
        phase_e            phase;
        logic [4:0]        bitcnt;
        logic [ADDR_W-1:0] addr;
        logic [1:0]        nbytes;
        logic [7:0]        rx;
        logic [REG_W-1:0]  tx;
        logic              dout;
        logic              oe;
        logic              sclk_prev;
        logic              we;
        logic [1:0]        wsel;
        logic [7:0]        wdata;
    } ctrl_s;

    localparam ctrl_s CTRL_RST = '{phase: PH_CMD, nbytes: 2'd1, sclk_prev: 1'b1, default: '0};

    ctrl_s      q, d;
    logic       fall, rise, last;
    logic [7:0] rx_new;
    logic [4:0] last_idx;

    function automatic logic [REG_W-1:0] left_align(input logic [REG_W-1:0] v, input logic [1:0] nb);
        case (nb)
            2'd1:    return {v[7:0],  16'h0000};
            2'd2:    return {v[15:0], 8'h00};
            default: return v;
        endcase
    endfunction

    assign fall     = q.sclk_prev & ~sclk_s;
    assign rise     = ~q.sclk_prev & sclk_s;
    assign rx_new   = {q.rx[6:0], sdi_s};
    assign raddr    = rx_new[ADDR_W-1:0];
    assign last_idx = {q.nbytes, 3'b000} - 5'd1;
    assign last     = (q.bitcnt == last_idx);

    always_comb begin
        d           = q;
        d.we        = 1'b0;
        d.sclk_prev = sclk_s;
        if (cs_s) begin
            d.phase  = PH_CMD;
            d.bitcnt = '0;
            d.oe     = 1'b0;
        end else if (fall) begin
            d.rx = rx_new;
            unique case (q.phase)
                PH_CMD: begin
                    if (q.bitcnt == 5'd7) begin
                        d.addr   = rx_new[ADDR_W-1:0];
                        d.nbytes = rb_bytes(rx_new[ADDR_W-1:0], NUM_REGS);
                        d.bitcnt = '0;
                        if (rx_new[7]) begin
                            d.phase = PH_WR;
                        end else begin
                            d.phase = PH_RD;
                            d.oe    = 1'b1;
                            d.tx    = left_align(rdata, rb_bytes(rx_new[ADDR_W-1:0], NUM_REGS));
                        end
                    end else begin
                        d.bitcnt = q.bitcnt + 5'd1;
                    end
                end
                PH_WR: begin
                    if (q.bitcnt[2:0] == 3'd7) begin
                        d.we    = 1'b1;
                        d.wsel  = q.nbytes - 2'd1 - q.bitcnt[4:3];
                        d.wdata = rx_new;
                    end
                    if (last) begin
                        d.phase  = PH_CMD;
                        d.bitcnt = '0;
                    end else begin
                        d.bitcnt = q.bitcnt + 5'd1;
                    end
                end
                default: begin
                    if (last) begin
                        d.phase  = PH_CMD;
                        d.bitcnt = '0;
                        d.oe     = 1'b0;
                    end else begin
                        d.bitcnt = q.bitcnt + 5'd1;
                    end
                end
            endcase
        end else if (rise && q.phase == PH_RD) begin
            d.dout = q.tx[REG_W-1];
            d.tx   = {q.tx[REG_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= CTRL_RST;
        else        q <= d;
    end

    assign we     = q.we;
    assign waddr  = q.addr;
    assign wsel   = q.wsel;
    assign wdata  = q.wdata;
    assign sdo    = q.dout;
    assign sdo_oe = q.oe;

    // R1: output bit moves only after a detected rising serial edge
    assert_sdo_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> $stable(sdo));
    // R3: deselection releases the pad
    assert_oe_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !sdo_oe);
    // R4: deselection leaves the block waiting for a command byte
    assert_cmd_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> (q.phase == PH_CMD && q.bitcnt == 5'd0));
    // R5: data phases never count past the addressed width
    assert_bitcnt_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase != PH_CMD) |-> (q.bitcnt <= last_idx && q.nbytes != 2'd0));
endmodule

// File: rtl/spi_regbank_slave.sv
module spi_regbank_slave
    import spi_rb_pkg::*;
#(
    parameter int NUM_REGS    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic sdi,
    output logic sdo,
    output logic sdo_oe
);
    logic [2:0]        pins_s;
    logic [REG_W-1:0]  rdata;
    logic [ADDR_W-1:0] raddr, waddr;
    logic              we;
    logic [1:0]        wsel;
    logic [7:0]        wdata;

    spi_rb_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sclk, cs_n, sdi}),
        .sync_o  (pins_s)
    );

    spi_rb_ctrl #(.NUM_REGS(NUM_REGS)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk_s (pins_s[2]),
        .cs_s   (pins_s[1]),
        .sdi_s  (pins_s[0]),
        .rdata  (rdata),
        .raddr  (raddr),
        .we     (we),
        .waddr  (waddr),
        .wsel   (wsel),
        .wdata  (wdata),
        .sdo    (sdo),
        .sdo_oe (sdo_oe)
    );

    spi_rb_regfile #(.NUM_REGS(NUM_REGS)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we),
        .waddr (waddr),
        .wsel  (wsel),
        .wdata (wdata),
        .raddr (raddr),
        .rdata (rdata)
    );
endmodule

// File: tb/spi_regbank_slave_test.sv
module spi_regbank_slave_test;
    localparam int H   = 6;
    localparam int NUM = 16;

    logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b1, cs_n = 1'b1, sdi = 1'b0;
    logic sdo, sdo_oe;
    int   checks = 0, fails = 0, glitch = 0;
    bit   done = 1'b0;
    logic [23:0] model [NUM];

    always #4 clk = ~clk;

    spi_regbank_slave uut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n),
        .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe)
    );

    function automatic int bits_of(int a);
        if (a >= NUM) return 8;
        case (a % 4)
            0: return 8;
            1: return 12;
            2: return 16;
            default: return 24;
        endcase
    endfunction

    function automatic int nb_of(int a);
        return (bits_of(a) + 7) / 8;
    endfunction

    function automatic logic [23:0] expect_of(int a);
        return (a < NUM) ? model[a] : 24'h0;
    endfunction

    task automatic chk(bit ok, string req, logic [23:0] act, logic [23:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = 8'h00;
        for (int i = 7; i > 7 - nbits; i--) begin
            logic p;
            sdi = tx[i];
            wait_clk(H);
            rx[i] = sdo;
            p = sdo;
            sclk = 1'b0;
            wait_clk(H - 1);
            if (sdo !== p) glitch++;
            wait_clk(1);
            sclk = 1'b1;
        end
    endtask

    task automatic cs_begin();
        cs_n = 1'b0;
        wait_clk(H);
    endtask

    task automatic cs_end();
        wait_clk(H);
        cs_n = 1'b1;
        wait_clk(H);
    endtask

    task automatic model_byte(int a, int k, logic [7:0] b);
        int sh;
        if (a < NUM) begin
            sh = 8 * (nb_of(a) - 1 - k);
            model[a][sh +: 8] = b;
            model[a] = model[a] & 24'((32'd1 << bits_of(a)) - 1);
        end
    endtask

    task automatic xact_write(int a, bit b6, logic [23:0] data);
        logic [7:0] rx;
        int nb;
        nb = nb_of(a);
        shift_bits({1'b1, b6, 6'(a)}, 8, rx);
        for (int k = 0; k < nb; k++) begin
            logic [7:0] b;
            b = 8'(data >> (8 * (nb - 1 - k)));
            shift_bits(b, 8, rx);
            model_byte(a, k, b);
        end
    endtask

    task automatic xact_read(int a, bit b6, output logic [23:0] val);
        logic [7:0] rx;
        val = 24'h0;
        shift_bits({1'b0, b6, 6'(a)}, 8, rx);
        for (int k = 0; k < nb_of(a); k++) begin
            shift_bits(8'h00, 8, rx);
            val = {val[15:0], rx};
        end
    endtask

    task automatic wr(int a, logic [23:0] data);
        cs_begin();
        xact_write(a, 1'b0, data);
        cs_end();
    endtask

    task automatic rd_chk(int a, string req);
        logic [23:0] v;
        cs_begin();
        xact_read(a, 1'b0, v);
        cs_end();
        chk(v === expect_of(a), req, v, expect_of(a));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0]  rx;
        logic [23:0] v;
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < NUM; i++) model[i] = 24'h0;
        wait_clk(5);
        // R10: reset state of the pad
        chk(sdo_oe === 1'b0, "R10 oe in reset", 24'(sdo_oe), 24'h0);
        chk(sdo === 1'b0, "R10 sdo in reset", 24'(sdo), 24'h0);
        rst_n = 1'b1;
        wait_clk(4);
        for (int a = 0; a < NUM; a++) rd_chk(a, "R10 register cleared");

        // R5 R6 R7: 12-bit register drops upper nibble of first byte
        wr(1, 24'h00FABC);
        rd_chk(1, "R7 right-justified 12-bit");
        chk(model[1] === 24'h000ABC, "R7 model sanity", model[1], 24'h000ABC);
        // R6: 24-bit register, most significant byte first
        wr(3, 24'h123456);
        rd_chk(3, "R6 24-bit byte order");
        wr(0, 24'h0000A5);
        rd_chk(0, "R5 8-bit register");
        wr(2, 24'h00BEEF);
        rd_chk(2, "R5 16-bit register");

        // R2: bit 6 of the command byte is ignored on write and read
        cs_begin();
        xact_write(6, 1'b1, 24'h00C3D2);
        cs_end();
        cs_begin();
        xact_read(6, 1'b1, v);
        cs_end();
        chk(v === 24'h00C3D2, "R2 bit6 ignored", v, 24'h00C3D2);

        // R9: unimplemented address, one byte, write ignored, reads zero
        cs_begin();
        xact_write(40, 1'b0, 24'h0000FF);
        xact_read(40, 1'b0, v);
        chk(v === 24'h0, "R9 unimplemented reads zero", v, 24'h0);
        xact_read(3, 1'b0, v);
        cs_end();
        chk(v === 24'h123456, "R9 one-byte length keeps framing", v, 24'h123456);

        // R3: abort inside third byte keeps the first two bytes only
        cs_begin();
        shift_bits({2'b10, 6'd7}, 8, rx);
        shift_bits(8'h11, 8, rx); model_byte(7, 0, 8'h11);
        shift_bits(8'h22, 8, rx); model_byte(7, 1, 8'h22);
        shift_bits(8'h33, 4, rx);
        cs_n = 1'b1;
        wait_clk(H);
        rd_chk(7, "R3 partial byte discarded");

        // R3: pad enabled during read, released after abort
        cs_begin();
        shift_bits({2'b00, 6'd3}, 8, rx);
        wait_clk(H);
        chk(sdo_oe === 1'b1, "R3 oe during read", 24'(sdo_oe), 24'h1);
        shift_bits(8'h00, 5, rx);
        cs_n = 1'b1;
        wait_clk(H);
        chk(sdo_oe === 1'b0, "R3 oe after abort", 24'(sdo_oe), 24'h0);

        // R4: half a command byte then deselect; next selection starts fresh
        cs_begin();
        shift_bits(8'hFF, 3, rx);
        cs_n = 1'b1;
        wait_clk(H);
        rd_chk(3, "R4 restart after partial command");

        // R8: back-to-back transactions in one selection
        cs_begin();
        xact_write(5, 1'b0, 24'h00F123);
        xact_read(5, 1'b0, v);
        chk(v === expect_of(5), "R8 back-to-back read", v, expect_of(5));
        xact_write(11, 1'b0, 24'hABCDEF);
        xact_read(11, 1'b0, v);
        chk(v === expect_of(11), "R8 second pair", v, expect_of(11));
        cs_end();

        // Random mix against the model
        for (int n = 0; n < 110; n++) begin
            int a;
            a = int'($urandom_range(0, 63));
            if ($urandom_range(0, 3) != 0) a = a % NUM;
            if ($urandom_range(0, 1) == 1) begin
                wr(a, 24'($urandom));
            end else begin
                rd_chk(a, "R5 R6 R7 R9 random read");
            end
        end
        // R1: sdo never moved while sclk was low
        chk(glitch == 0, "R1 sdo stable while sclk low", 24'(glitch), 24'h0);

        // R10: reset mid-run clears registers
        rst_n = 1'b0;
        wait_clk(4);
        rst_n = 1'b1;
        for (int i = 0; i < NUM; i++) model[i] = 24'h0;
        wait_clk(4);
        rd_chk(3, "R10 cleared by reset");
        rd_chk(11, "R10 cleared by reset");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule